// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI master from the system bus clock. It also emits single-cycle strobes that tell the shift engine when the clock rises and when it falls. The division ratio comes from an 8-bit divide value and a one-bit law select, and the select picks one of two laws:

- Exponential law (select 0): the half period is 2^N bus clocks. Only the low four bits of N are used, so the full period ranges from 2 to 65536 bus clocks.
- Linear law (select 1): the half period is N+1 bus clocks. The full period is 2×(N+1), for N from 0 to 255.

The clock always idles low. The shift engine applies polarity downstream.

The divide value and the law select are captured into a shadow register on every cycle while `enable` is low. They are frozen while it is high. A state machine sequences the clock through four states:

- `SC_OFF`: the block is disabled.
- `SC_IDLE`: enabled, no frame running.
- `SC_LOW`: the low half of the clock.
- `SC_HIGH`: the high half of the clock.

Its transitions are:

- OFF→IDLE when enable rises.
- Any state→OFF when enable falls.
- IDLE→LOW when run is sampled high.
- LOW→HIGH at the end of a half period.
- HIGH→LOW at the end of a half period while run is still high.
- HIGH→IDLE at the end of a half period once run is low.
- LOW→IDLE as soon as run is low.

A phase counter is held at zero outside LOW and HIGH. It restarts at every toggle.

Top module: `sclk_rate_gen`

## Requirements
- R1: While reset is asserted and directly after it, `sclk`, `lead_stb` and `trail_stb` are 0.
- R2: With `law_sel`=0, each high and each low half of `sclk` lasts exactly 2^N bus clocks, where N = `div_value[3:0]`.
- R3: With `law_sel`=0, bits 7:4 of `div_value` are ignored (N=0x13 gives the same 8-cycle half period as N=3).
- R4: With `law_sel`=1, each high and each low half of `sclk` lasts exactly N+1 bus clocks, where N = `div_value`.
- R5: `div_value` and `law_sel` changes made while `enable` is 1 have no effect. The value present on the last cycle `enable` was 0 governs.
- R6: The first rising edge of `sclk` appears exactly one half period, H bus clock edges, after the edge that samples `run`=1 in the idle state.
- R7: `lead_stb` is 1 for exactly the first cycle of each high half, and `trail_stb` for exactly the first low cycle after each high half. The two are never 1 together.
- R8: When `run` falls during a low half, the clock stops at once with no further rising edge. When it falls during a high half, that half completes to its full length, ends with a `trail_stb`, and no further rising edge follows.
- R9: One edge after `enable` is sampled 0, `sclk` is 0 and no strobe is issued, even in mid high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable; configuration is captured while low |
| run | input | 1 | Frame active request from the shift engine |
| law_sel | input | 1 | 0 = exponential law, 1 = linear law |
| div_value | input | 8 | Divide value N |
| sclk | output | 1 | Serial clock level, idle low |
| lead_stb | output | 1 | One-cycle strobe on each rising edge of sclk |
| trail_stb | output | 1 | One-cycle strobe on each falling edge of sclk |

## Verification
Two functions can land on the same cycle: withdrawing `run` and ending a half period. When `run` is dropped just as the high half begins, the end of that half must both finish the clock cycle and retire the frame. The bench judges this by counting the high width, requiring a `trail_stb` on the falling edge, and requiring no later rising edge. Disabling the block in mid high half is checked the same way: the falling edge must arrive on the next cycle with no trailing strobe.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    typedef enum logic [1:0] {
        SC_OFF  = 2'd0,
        SC_IDLE = 2'd1,
        SC_LOW  = 2'd2,
        SC_HIGH = 2'd3
    } sc_state_e;
endpackage

// File: rtl/sclk_cfg_hold.sv
// Shadow copy of the divide setting, turned into a half-period terminal count.
module sclk_cfg_hold #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             law_sel,
    input  logic [DIV_W-1:0] div_value,
    output logic [CNT_W-1:0] half_m1
);
    logic [CNT_W-1:0] next_half_m1;

    always_comb begin
        if (law_sel)
            next_half_m1 = CNT_W'(div_value);
        else
            next_half_m1 = (CNT_W'(1) << div_value[EXP_W-1:0]) - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            half_m1 <= '0;
        else if (!enable)
            half_m1 <= next_half_m1;
    end

    // R5: configuration frozen while enabled
    p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(half_m1));
endmodule

// File: rtl/sclk_phase_timer.sv
// Counts bus clocks within one half period of the serial clock.
module sclk_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic [CNT_W-1:0] half_m1,
    output logic             terminal
);
    logic [CNT_W-1:0] cnt_q;

    assign terminal = count_en && (cnt_q == half_m1);

    always_ff @(posedge clk) begin
        if (!rst_n || !count_en)
            cnt_q <= '0;
        else if (terminal)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R2: the counter never passes the terminal count
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |-> (cnt_q <= half_m1));
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic             law_sel,
    input  logic [DIV_W-1:0] div_value,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    import sclk_pkg::*;

    localparam int CNT_W = 1 << EXP_W;

    sc_state_e        state_q, state_d;
    logic [CNT_W-1:0] half_m1;
    logic             terminal;
    logic             counting;

    assign counting = (state_q == SC_LOW) || (state_q == SC_HIGH);

    sclk_cfg_hold #(.DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .law_sel  (law_sel),
        .div_value(div_value),
        .half_m1  (half_m1)
    );

    sclk_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(counting),
        .half_m1 (half_m1),
        .terminal(terminal)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_OFF:  if (enable) state_d = SC_IDLE;
            SC_IDLE: begin
                if (!enable)  state_d = SC_OFF;
                else if (run) state_d = SC_LOW;
            end
            SC_LOW: begin
                if (!enable)       state_d = SC_OFF;
                else if (!run)     state_d = SC_IDLE;
                else if (terminal) state_d = SC_HIGH;
            end
            SC_HIGH: begin
                if (!enable)       state_d = SC_OFF;
                else if (terminal) state_d = run ? SC_LOW : SC_IDLE;
            end
            default: state_d = SC_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SC_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk      <= 1'b0;
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else begin
            sclk      <= (state_d == SC_HIGH);
            lead_stb  <= (state_q == SC_LOW) && (state_d == SC_HIGH);
            trail_stb <= (state_q == SC_HIGH) &&
                         ((state_d == SC_LOW) || (state_d == SC_IDLE));
        end
    end

    // R9: disable silences the clock on the next edge
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sclk && !lead_stb && !trail_stb));
    // R7: strobes coincide with the matching level change
    p_lead_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sclk && !$past(sclk)));
    p_trail_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (!sclk && $past(sclk)));
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));
    // R8: without a run request no new rising edge appears
    p_no_rise_wo_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !sclk) |=> !sclk);
endmodule

// File: tb/sim_sclk_rate_gen.sv
module sim_sclk_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       run = 1'b0;
    logic       law_sel = 1'b0;
    logic [7:0] div_value = 8'd0;
    logic       sclk, lead_stb, trail_stb;
    int         n_checks = 0;
    int         n_errors = 0;

    always #4ns clk = ~clk;

    sclk_rate_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
        .law_sel(law_sel), .div_value(div_value),
        .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic configure(input logic law, input logic [7:0] n);
        @(negedge clk);
        enable = 1'b0; run = 1'b0; law_sel = law; div_value = n;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    // run a frame; measure first rise, high, low; optionally stop in a high half
    task automatic measure(input string tag, input int exp_h, input bit full);
        int rise_n = 0, hw = 1, lw = 1, hw2 = 1, bad = 0;
        run = 1'b1;
        while (!sclk && rise_n < 70000) begin @(negedge clk); rise_n++; end
        check(rise_n - 1 == exp_h, {tag, " R6 first rise"}, rise_n - 1, exp_h);
        check(lead_stb == 1'b1, {tag, " R7 lead strobe"}, lead_stb, 1);
        while (hw < 70000) begin @(negedge clk); if (!sclk) break; hw++; end
        check(hw == exp_h, {tag, " high width"}, hw, exp_h);
        check(trail_stb == 1'b1, {tag, " R7 trail strobe"}, trail_stb, 1);
        if (full) begin
            while (lw < 70000) begin @(negedge clk); if (sclk) break; lw++; end
            check(lw == exp_h, {tag, " low width"}, lw, exp_h);
            run = 1'b0; // R8: drop while the high half just began
            while (hw2 < 70000) begin @(negedge clk); if (!sclk) break; hw2++; end
            check(hw2 == exp_h, {tag, " R8 last high completes"}, hw2, exp_h);
            check(trail_stb == 1'b1, {tag, " R8 final trail"}, trail_stb, 1);
            for (int i = 0; i < 2 * exp_h + 4; i++) begin
                @(negedge clk);
                if (sclk || lead_stb) bad++;
            end
            check(bad == 0, {tag, " R8 no edge after stop"}, bad, 0);
        end else begin
            run = 1'b0;
            enable = 1'b0;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(sclk == 0 && lead_stb == 0 && trail_stb == 0, "R1 outputs in reset",
              {sclk, lead_stb, trail_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk == 0 && lead_stb == 0 && trail_stb == 0, "R1 outputs after reset",
              {sclk, lead_stb, trail_stb}, 0);
    endtask

    task automatic t_frozen_cfg;
        configure(1'b1, 8'd3);
        div_value = 8'd0; law_sel = 1'b0; // ignored while enabled
        measure("R5 frozen N=3 lin", 4, 1'b1);
        configure(1'b1, 8'd0);
        measure("R5 new value N=0 lin", 1, 1'b1);
    endtask

    task automatic t_low_drop;
        int bad = 0;
        configure(1'b1, 8'd2);
        run = 1'b1;
        while (!sclk) @(negedge clk);
        while (sclk) @(negedge clk);
        run = 1'b0; // R8: low half in progress
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (sclk || lead_stb) bad++;
        end
        check(bad == 0, "R8 stop in low half", bad, 0);
    endtask

    task automatic t_disable_mid_high;
        configure(1'b1, 8'd4);
        run = 1'b1;
        while (!sclk) @(negedge clk);
        enable = 1'b0; // R9
        @(negedge clk);
        check(sclk == 0 && lead_stb == 0 && trail_stb == 0, "R9 disable mid high",
              {sclk, lead_stb, trail_stb}, 0);
        run = 1'b0;
    endtask

    initial begin
        t_reset();
        configure(1'b0, 8'd0);  measure("R2 exp N=0", 1, 1'b1);
        configure(1'b0, 8'd4);  measure("R2 exp N=4", 16, 1'b1);
        configure(1'b0, 8'h13); measure("R3 exp N=0x13", 8, 1'b1);
        configure(1'b1, 8'd0);  measure("R4 lin N=0", 1, 1'b1);
        configure(1'b1, 8'd6);  measure("R4 lin N=6", 7, 1'b1);
        configure(1'b1, 8'd255); measure("R4 lin N=255", 256, 1'b1);
        t_frozen_cfg();
        t_low_drop();
        t_disable_mid_high();
        configure(1'b0, 8'd15); measure("R2 exp N=15", 32768, 1'b0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(8ns * 190000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule